// File: doc/BRIEF.md
# Shared-Line Interrupt Router

This block sits between eight level-sensitive peripheral interrupt lines and the 24 global system interrupt (GSI) inputs of the interrupt controllers. Each peripheral line has two paths. It always drives its own dedicated advanced-controller pin, GSI 16 to 23. It can also be steered through a byte-wide routing register onto one of the sixteen legacy controller pins, GSI 0 to 15, and that pin may be shared with other peripheral lines. A legacy pin carries the OR of every line routed to it whose route is enabled.

A single power-management event level (SCI) is merged into one GSI chosen by a 3-bit select code. If software moves the SCI while it is asserted, the old pin drops first. The new pin rises one cycle later, so no controller ever sees the event on two pins at once. Software can also query each line's effective route through a combinational port. The eight routing registers are written through a plain indexed write port: index 0 to 3 is the first bank and 4 to 7 is the second. Every GSI output is registered.

Top module: `pirq_router`

## Requirements
- R1: While reset is held and right after it, every GSI output is 0. Every routing byte holds 0x80 (route disabled, target 0). The SCI select code is 0.
- R2: Line n drives GSI 16+n one clock after it is sampled, whatever its routing byte holds.
- R3: A legacy pin k (0 to 15) goes high one clock after any line whose routing byte has bit 7 clear and bits [4:0] equal to k is high. It stays low when no such line is high.
- R4: A routing byte with bit 7 set removes its line from every legacy pin. Bits 6:5 are ignored.
- R5: An enabled routing byte whose target field [4:0] is 16 or more drives no legacy pin.
- R6: The SCI level is ORed into one GSI chosen by the select code: code 0 picks GSI 9, 1 picks 10, 2 picks 11, 4 picks 20 and 5 picks 21.
- R7: Select codes 3, 6 and 7 leave the SCI connected to no GSI.
- R8: Suppose the select code is written to a new value while the SCI is high. The output cycle that follows the write still shows the SCI on the old pin. The next output cycle shows it on neither pin. From the cycle after that, it shows on the new pin only.
- R9: A query of a line whose routing byte has bit 7 set reports the route as enabled, with IRQ 16+n.
- R10: A query of an enabled line reports the route as enabled with the target when the target is below 16. When the target is 16 or more, it reports the route as disabled, with IRQ 0.
- R11: When every line and the SCI are low, all GSI outputs are low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pirq_i | input | 8 | Peripheral interrupt levels, line n in bit n |
| sci_i | input | 1 | Power-management event level |
| rt_we_i | input | 1 | Routing register write strobe |
| rt_idx_i | input | 3 | Routing register index (line number) |
| rt_wdata_i | input | 8 | Routing byte: bit 7 disable, bits 4:0 target |
| sci_sel_we_i | input | 1 | SCI select write strobe |
| sci_sel_i | input | 3 | New SCI select code |
| qry_idx_i | input | 3 | Line whose route is queried |
| qry_en_o | output | 1 | Queried route is enabled |
| qry_irq_o | output | 5 | GSI the queried line reaches |
| gsi_o | output | 24 | Registered GSI levels |

## Verification
The bench sweeps all 256 line patterns, with the SCI both low and high, under several routing setups. These setups include several lines sharing one legacy pin, and a legacy pin that the SCI also drives. A router that kept only the last matching line, instead of the OR, would fail the sharing cases. One that ignored the disable bit or let out-of-range targets wrap would light legacy pins that should stay dark. All eight select codes are stepped through. A decoder that gave reserved codes a pin would show a stray GSI. The select change while the SCI is high is checked cycle by cycle: a design without the gap would show the SCI on the new pin one cycle early, and one that never re-asserted would leave it low for good. Queries are checked for all three route kinds. Reporting an out-of-range target as enabled would be caught there.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned RT_W       = 8;
  localparam int unsigned RT_DIS_BIT = 7;
  localparam int unsigned RT_TGT_W   = 5;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned SCI_GSI_W  = 5;

  localparam logic [RT_W-1:0] RT_RESET = 8'h80;

  typedef struct packed {
    logic                 valid;
    logic [SCI_GSI_W-1:0] gsi;
  } sci_pin_t;

  function automatic sci_pin_t sci_decode(input logic [SEL_W-1:0] code);
    sci_pin_t r;
    r = '{valid: 1'b1, gsi: '0};
    unique case (code)
      3'd0:    r.gsi = 5'd9;
      3'd1:    r.gsi = 5'd10;
      3'd2:    r.gsi = 5'd11;
      3'd4:    r.gsi = 5'd20;
      3'd5:    r.gsi = 5'd21;
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  localparam int unsigned IDX_W = $clog2(NUM_PIRQ)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [RT_W-1:0]                wdata_i,
  output logic [NUM_PIRQ-1:0][RT_W-1:0]  route_o
);
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_rt
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(n));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  route_o[n] <= RT_RESET;
      else if (hit) route_o[n] <= wdata_i;
    end
  end
endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16
) (
  input  logic [NUM_PIRQ-1:0]            pirq_i,
  input  logic [NUM_PIRQ-1:0][RT_W-1:0]  route_i,
  output logic [NUM_PIC-1:0]             pic_o
);
  logic [NUM_PIRQ-1:0] en;
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_en
    // out-of-range targets never match a legacy pin
    assign en[n] = pirq_i[n] && !route_i[n][RT_DIS_BIT];
  end

  for (genvar k = 0; k < NUM_PIC; k++) begin : g_pin
    always_comb begin
      pic_o[k] = 1'b0;
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (en[n] && (route_i[n][RT_TGT_W-1:0] == RT_TGT_W'(k))) pic_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_sci_steer.sv
module pirq_sci_steer
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_GSI = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sci_i,
  input  logic               sel_we_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_GSI-1:0] sci_vec_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               gap_o
);
  logic [SEL_W-1:0] sel_q;
  logic             gap_q;
  sci_pin_t         pin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      gap_q <= 1'b0;
    end else begin
      if (sel_we_i) sel_q <= sel_i;
      // one blank cycle when a live SCI moves
      gap_q <= sel_we_i && (sel_i != sel_q) && sci_i;
    end
  end

  assign pin = sci_decode(sel_q);

  always_comb begin
    sci_vec_o = '0;
    if (sci_i && !gap_q && pin.valid && (32'(pin.gsi) < NUM_GSI))
      sci_vec_o[pin.gsi] = 1'b1;
  end

  assign sel_o = sel_q;
  assign gap_o = gap_q;
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16,
  localparam int unsigned NUM_GSI = NUM_PIC + NUM_PIRQ,
  localparam int unsigned IDX_W   = $clog2(NUM_PIRQ),
  localparam int unsigned GSI_W   = $clog2(NUM_GSI)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PIRQ-1:0] pirq_i,
  input  logic                sci_i,
  input  logic                rt_we_i,
  input  logic [IDX_W-1:0]    rt_idx_i,
  input  logic [RT_W-1:0]     rt_wdata_i,
  input  logic                sci_sel_we_i,
  input  logic [SEL_W-1:0]    sci_sel_i,
  input  logic [IDX_W-1:0]    qry_idx_i,
  output logic                qry_en_o,
  output logic [GSI_W-1:0]    qry_irq_o,
  output logic [NUM_GSI-1:0]  gsi_o
);
  logic [NUM_PIRQ-1:0][RT_W-1:0] route_q;
  logic [NUM_PIC-1:0]            pic_lvl;
  logic [NUM_GSI-1:0]            sci_vec;
  logic [SEL_W-1:0]              sci_sel;
  logic                          sci_gap;
  logic [NUM_GSI-1:0]            gsi_d;
  logic [RT_W-1:0]               qry_rt;

  pirq_route_regs #(.NUM_PIRQ(NUM_PIRQ)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rt_we_i),
    .idx_i   (rt_idx_i),
    .wdata_i (rt_wdata_i),
    .route_o (route_q)
  );

  pirq_pic_merge #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) u_merge (
    .pirq_i  (pirq_i),
    .route_i (route_q),
    .pic_o   (pic_lvl)
  );

  pirq_sci_steer #(.NUM_GSI(NUM_GSI)) u_sci (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sci_i     (sci_i),
    .sel_we_i  (sci_sel_we_i),
    .sel_i     (sci_sel_i),
    .sci_vec_o (sci_vec),
    .sel_o     (sci_sel),
    .gap_o     (sci_gap)
  );

  assign gsi_d = {pirq_i, pic_lvl} | sci_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gsi_o <= '0;
    else         gsi_o <= gsi_d;
  end

  assign qry_rt = route_q[qry_idx_i];

  always_comb begin
    if (qry_rt[RT_DIS_BIT]) begin
      qry_en_o  = 1'b1;
      qry_irq_o = GSI_W'(NUM_PIC) + GSI_W'(qry_idx_i);
    end else if (32'(qry_rt[RT_TGT_W-1:0]) < NUM_PIC) begin
      qry_en_o  = 1'b1;
      qry_irq_o = GSI_W'(qry_rt[RT_TGT_W-1:0]);
    end else begin
      qry_en_o  = 1'b0;
      qry_irq_o = '0;
    end
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned NUM_PIC  = 16,
  localparam int unsigned NUM_GSI = NUM_PIC + NUM_PIRQ,
  localparam int unsigned IDX_W   = $clog2(NUM_PIRQ),
  localparam int unsigned GSI_W   = $clog2(NUM_GSI)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_PIRQ-1:0]           pirq_i,
  input logic                          sci_i,
  input logic [IDX_W-1:0]              qry_idx_i,
  input logic                          qry_en_o,
  input logic [GSI_W-1:0]              qry_irq_o,
  input logic [NUM_GSI-1:0]            gsi_o,
  input logic [NUM_PIRQ-1:0][RT_W-1:0] route_q,
  input logic [SEL_W-1:0]              sel_q,
  input logic                          gap_q
);
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_apic
    if ((NUM_PIC + n != 20) && (NUM_PIC + n != 21)) begin : g_chk
      p_apic_direct_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> gsi_o[NUM_PIC+n] == $past(pirq_i[n]));
    end
  end

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pirq_i == '0 && !sci_i) |=> gsi_o == '0);

  p_sci_gsi9_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sci_i && pirq_i == '0 && sel_q == 3'd0 && !gap_q) |=> gsi_o == (NUM_GSI'(1) << 9));

  p_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pirq_i == '0 && (sel_q == 3'd3 || sel_q == 3'd6 || sel_q == 3'd7)) |=> gsi_o == '0);

  p_qry_apic_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_q[qry_idx_i][RT_DIS_BIT] |-> (qry_en_o && qry_irq_o == GSI_W'(NUM_PIC) + GSI_W'(qry_idx_i)));

  p_qry_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_q[qry_idx_i][RT_DIS_BIT] && 32'(route_q[qry_idx_i][RT_TGT_W-1:0]) >= NUM_PIC)
    |-> !qry_en_o);
endmodule

bind pirq_router pirq_router_chk #(.NUM_PIRQ(NUM_PIRQ), .NUM_PIC(NUM_PIC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pirq_i    (pirq_i),
  .sci_i     (sci_i),
  .qry_idx_i (qry_idx_i),
  .qry_en_o  (qry_en_o),
  .qry_irq_o (qry_irq_o),
  .gsi_o     (gsi_o),
  .route_q   (route_q),
  .sel_q     (sci_sel),
  .gap_q     (sci_gap)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pirq = '0;
  logic        sci = 1'b0;
  logic        rt_we = 1'b0;
  logic [2:0]  rt_idx = '0;
  logic [7:0]  rt_wdata = '0;
  logic        sel_we = 1'b0;
  logic [2:0]  sel = '0;
  logic [2:0]  qidx = '0;
  logic        qen;
  logic [4:0]  qirq;
  logic [23:0] gsi;

  int checks = 0;
  int errors = 0;
  logic [7:0] rt [8];
  logic [2:0] cur_sel = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pirq_router u_pirq_router (
    .clk_i(clk), .rst_ni(rst_n), .pirq_i(pirq), .sci_i(sci),
    .rt_we_i(rt_we), .rt_idx_i(rt_idx), .rt_wdata_i(rt_wdata),
    .sci_sel_we_i(sel_we), .sci_sel_i(sel), .qry_idx_i(qidx),
    .qry_en_o(qen), .qry_irq_o(qirq), .gsi_o(gsi)
  );

  function automatic int sci_pin(input logic [2:0] c);
    case (c)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] exp_gsi(input logic [7:0] p, input logic s, input logic [2:0] c);
    logic [23:0] e = '0;
    for (int n = 0; n < 8; n++) begin
      if (p[n]) begin
        e[16+n] = 1'b1;
        if (!rt[n][7] && rt[n][4:0] < 5'd16) e[rt[n][4:0]] = 1'b1;
      end
    end
    if (s && sci_pin(c) >= 0) e[sci_pin(c)] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_route(input int n, input logic [7:0] b);
    @(negedge clk);
    rt_we = 1'b1; rt_idx = 3'(n); rt_wdata = b; rt[n] = b;
    @(negedge clk);
    rt_we = 1'b0;
  endtask

  task automatic wr_sel(input logic [2:0] c);
    @(negedge clk);
    sel_we = 1'b1; sel = c;
    @(negedge clk);
    sel_we = 1'b0; cur_sel = c;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        pirq = 8'(p); sci = s[0];
        @(negedge clk);
        chk(req, 32'(gsi), 32'(exp_gsi(8'(p), s[0], cur_sel)));
      end
    end
    @(negedge clk);
    pirq = '0; sci = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) rt[n] = 8'h80;
    repeat (3) @(negedge clk);
    chk("R1 gsi in reset", 32'(gsi), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gsi after reset", 32'(gsi), 32'h0);
    for (int n = 0; n < 8; n++) begin
      qidx = 3'(n); #1;
      chk("R1 R9 reset query", {26'b0, qen, qirq}, {26'b0, 1'b1, 5'(16 + n)});
    end

    // R2/R4: all disabled, sweep; only dedicated pins (and SCI on 9)
    sweep("R2 R4 disabled routes");

    // R3: pairs share pins, bits 6:5 set to show they are ignored (R4)
    for (int n = 0; n < 8; n++) wr_route(n, 8'h60 | 8'((n % 4) + 4));
    sweep("R3 shared legacy pins");

    // R5 + mixed: targets beyond range, some disabled, one on SCI pin 9
    wr_route(0, 8'h10); wr_route(1, 8'h17); wr_route(2, 8'h09); wr_route(3, 8'h80);
    wr_route(4, 8'h09); wr_route(5, 8'h1F); wr_route(6, 8'h8F); wr_route(7, 8'h00);
    wr_sel(3'd1);
    sweep("R5 R3 mixed targets");
    wr_sel(3'd4);
    sweep("R6 sci on apic pin");

    // R10 / R9 queries
    for (int n = 0; n < 8; n++) begin
      qidx = 3'(n); #1;
      if (rt[n][7])
        chk("R9 query disabled", {26'b0, qen, qirq}, {26'b0, 1'b1, 5'(16 + n)});
      else if (rt[n][4:0] < 5'd16)
        chk("R10 query legacy", {26'b0, qen, qirq}, {26'b0, 1'b1, rt[n][4:0]});
      else
        chk("R10 query out of range", {26'b0, qen, qirq}, 32'h0);
    end

    // R6/R7: every select code, SCI high only
    for (int c = 0; c < 8; c++) begin
      wr_sel(3'(c));
      @(negedge clk); sci = 1'b1; pirq = '0;
      @(negedge clk);
      chk(sci_pin(3'(c)) < 0 ? "R7 reserved code" : "R6 code map",
          32'(gsi), sci_pin(3'(c)) < 0 ? 32'h0 : (32'h1 << sci_pin(3'(c))));
      sci = 1'b0;
      @(negedge clk);
    end

    // R8: move live SCI from 9 to 10
    wr_sel(3'd0);
    @(negedge clk); sci = 1'b1;
    @(negedge clk);
    chk("R8 before move", 32'(gsi), 32'h200);
    sel_we = 1'b1; sel = 3'd1;
    @(negedge clk);
    sel_we = 1'b0;
    chk("R8 old pin still", 32'(gsi), 32'h200);
    @(negedge clk);
    chk("R8 gap cycle", 32'(gsi), 32'h0);
    @(negedge clk);
    chk("R8 new pin", 32'(gsi), 32'h400);
    @(negedge clk);
    chk("R8 new pin holds", 32'(gsi), 32'h400);
    sci = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11 all low", 32'(gsi), 32'h0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule